// File: doc/BRIEF.md
# Colour Palette Host Access Port

This block is the host-side register window of a colour lookup table. A host reaches four targets over one synchronous bus with chip select, read and write strobes and a two-bit target select. The targets are an 8-bit address register, a mode register, a small bank of control registers, and a 256-entry palette. Each palette entry holds a red, a green and a blue colour word.

Palette traffic is sequential. The host writes a start address once and then streams colours in the order red, green, blue. The address moves on by one only after the blue word of a triple has been transferred, and it wraps at the top of the table. Two mode bits set the transfer format. One sets the stored colour precision to 10 or 8 bits. The other sets the host bus width to 10 or 8 bits. With a narrow bus at full precision, each colour takes two transfers: the eight upper bits first, then the two lower bits.

A registered lookup port gives the pixel side the full entry at any index. It applies the precision mask, which zeroes the two low bits of every colour when 8-bit precision is selected.

Top module: `clut_host_port`

## Requirements
- R1: After reset the address register reads 0 and the mode register reads 0x0FF. Control register 0 reads 0x00, and control registers 1 and 2 read 0xFF.
- R2: Select code 0 reaches the address register. A write takes the data bits 7..0. A read returns the stored address with bits 9..8 at 0.
- R3: Select code 2 reaches the mode register. Only data bits 7..0 are stored, and bits 9..8 always read back as 0.
- R4: Select code 1 reaches the palette. Successive transfers go to red, green and blue of the entry at the address register. The address increments by one only after the blue transfer.
- R5: Palette reads follow the same red, green, blue order and the same increment as writes. Each read result appears on rdata one cycle after the read strobe.
- R6: When the address is 255, completing a triple moves it to 0.
- R7: A write to the address register restarts the colour order at red.
- R8: Mode bit 1 = 0 selects 8-bit precision. Each colour then moves in one transfer on data bits 7..0 and is stored as that value followed by two zero bits. The lookup port also returns the two low bits of every colour as 0.
- R9: Mode bit 2 = 0 with mode bit 1 = 1 selects the narrow bus. Each colour takes two transfers: bits 9..2 on data 7..0, then bits 1..0 on data 1..0. The entry is changed only by the second transfer, and reads return the same two parts with bits 9..8 at 0.
- R10: With mode bits 2 and 1 both 1, each colour moves as one full 10-bit transfer.
- R11: The op_normal output is 1 only when mode bits 4..3 hold the code 01.
- R12: One cycle after lk_idx is applied, lk_rgb holds that entry with red in bits 29..20, green in bits 19..10 and blue in bits 9..0.
- R13: Select code 3 reaches control register number address[1:0]. Control registers are 8 bits wide and read back with bits 9..8 at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, sampled with cs |
| wr | input | 1 | Write strobe, sampled with cs |
| sel | input | 2 | Target select: 0 address, 1 palette, 2 mode, 3 control |
| wdata | input | 10 | Host write data |
| rdata | output | 10 | Host read data, registered |
| op_normal | output | 1 | Operating field holds the normal code |
| lk_idx | input | 8 | Pixel-side lookup index |
| lk_rgb | output | 30 | Registered lookup result, red in the top bits |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 10-bit colours, an 8-bit narrow bus, three colour lanes and three control registers. With this build the 255-to-0 address wrap is reached with a single address write. The mask and the two-step transfer are each exactly two bits wide, so every precision and bus-width combination can be checked against hand-computed values. Partial triples and mode changes between entries are driven on purpose, so that the increment point and the commit point are observed from the address readback and the lookup port.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_PAL  = 2'd1,
      SEL_MODE = 2'd2,
      SEL_CTRL = 2'd3
   } sel_e;

   // mode register bit positions
   localparam int MB_RES    = 1;   // 1: full colour precision
   localparam int MB_BUS    = 2;   // 1: wide host bus
   localparam int MB_OP_LO  = 3;   // two-bit operating field
   localparam logic [1:0] OP_NORMAL = 2'b01;
endpackage

// File: rtl/clut_seq.sv
module clut_seq #(
   parameter int ADDR_W = 8,
   parameter int NCOL   = 3,
   localparam int PTR_W = (NCOL > 1) ? $clog2(NCOL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              step,
   input  logic              two_step,
   output logic [ADDR_W-1:0] addr_q,
   output logic [PTR_W-1:0]  ptr_q,
   output logic              phase_q,
   output logic              col_done
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NCOL - 1);

   assign col_done = step & (~two_step | phase_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         ptr_q   <= '0;
         phase_q <= 1'b0;
      end else if (addr_we) begin
         addr_q  <= addr_d;
         ptr_q   <= '0;
         phase_q <= 1'b0;
      end else if (step) begin
         if (two_step && !phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            if (ptr_q == LAST) begin
               ptr_q  <= '0;
               addr_q <= addr_q + 1'b1;
            end else begin
               ptr_q <= ptr_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/clut_palette_ram.sv
module clut_palette_ram #(
   parameter int ADDR_W = 8,
   parameter int COL_W  = 10,
   parameter int NCOL   = 3,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int PIX_W = NCOL * COL_W
) (
   input  logic              clk,
   input  logic [NCOL-1:0]   we_lane,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [COL_W-1:0]  wval,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [PIX_W-1:0]  rval_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [PIX_W-1:0]  rval_b
);
   // lane 0 sits in the most significant slice
   for (genvar g = 0; g < NCOL; g++) begin : g_lane
      logic [COL_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we_lane[g]) mem[waddr] <= wval;
      end
      assign rval_a[(NCOL-1-g)*COL_W +: COL_W] = mem[raddr_a];
      assign rval_b[(NCOL-1-g)*COL_W +: COL_W] = mem[raddr_b];
   end
endmodule

// File: rtl/clut_ctrl_regs.sv
module clut_ctrl_regs #(
   parameter int NREG   = 3,
   parameter int CTRL_W = 8,
   parameter int IDX_W  = 2,
   parameter logic [NREG*CTRL_W-1:0] RST_VALS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [CTRL_W-1:0] wval,
   output logic [CTRL_W-1:0] rval
);
   logic [CTRL_W-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (!rst_n)
            regs[i] <= RST_VALS[i*CTRL_W +: CTRL_W];
         else if (we && idx == IDX_W'(i))
            regs[i] <= wval;
      end
   end

   always_comb begin
      rval = '0;
      for (int i = 0; i < NREG; i++)
         if (idx == IDX_W'(i)) rval = regs[i];
   end
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
   import clut_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int COL_W    = 10,
   parameter int NARROW_W = 8,
   parameter int NCOL     = 3,
   parameter int CTRL_W   = 8,
   parameter int NCTRL    = 3,
   parameter logic [NCTRL*CTRL_W-1:0] CTRL_RST = {8'hFF, 8'hFF, 8'h00}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs,
   input  logic                  rd,
   input  logic                  wr,
   input  logic [1:0]            sel,
   input  logic [COL_W-1:0]      wdata,
   output logic [COL_W-1:0]      rdata,
   output logic                  op_normal,
   input  logic [ADDR_W-1:0]     lk_idx,
   output logic [NCOL*COL_W-1:0] lk_rgb
);
   localparam int BUS_W  = COL_W;
   localparam int LSB_W  = COL_W - NARROW_W;
   localparam int MODE_W = 8;
   localparam int PIX_W  = NCOL * COL_W;
   localparam int PTR_W  = (NCOL > 1) ? $clog2(NCOL) : 1;
   localparam int CIDX_W = (NCTRL > 1) ? $clog2(NCTRL) : 1;

   if (COL_W <= NARROW_W) begin : g_chk_col
      $error("COL_W must exceed NARROW_W");
   end
   if (NARROW_W < ADDR_W || NARROW_W < MODE_W || NARROW_W < CTRL_W) begin : g_chk_nar
      $error("narrow bus must carry address, mode and control values");
   end
   if (ADDR_W < CIDX_W) begin : g_chk_idx
      $error("address too narrow to index control registers");
   end
   if (MODE_W <= MB_OP_LO + 1) begin : g_chk_mode
      $error("mode register too narrow");
   end

   sel_e sel_t;
   assign sel_t = sel_e'(sel);

   logic wr_en, rd_en;
   assign wr_en = cs & wr;
   assign rd_en = cs & rd & ~wr;

   // ---------------- mode register ----------------
   logic [MODE_W-1:0] mode_q;
   logic res10, bus10, two_step;

   always_ff @(posedge clk) begin
      if (!rst_n)                              mode_q <= '1;
      else if (wr_en && sel_t == SEL_MODE)     mode_q <= wdata[MODE_W-1:0];
   end

   assign res10     = mode_q[MB_RES];
   assign bus10     = mode_q[MB_BUS];
   assign two_step  = res10 & ~bus10;
   assign op_normal = (mode_q[MB_OP_LO +: 2] == OP_NORMAL);

   // ---------------- address and colour sequence ----------------
   logic              addr_we, pal_step, col_done, phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PTR_W-1:0]  ptr_q;

   assign addr_we  = wr_en & (sel_t == SEL_ADDR);
   assign pal_step = (wr_en | rd_en) & (sel_t == SEL_PAL);

   clut_seq #(.ADDR_W(ADDR_W), .NCOL(NCOL)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_we  (addr_we),
      .addr_d   (wdata[ADDR_W-1:0]),
      .step     (pal_step),
      .two_step (two_step),
      .addr_q   (addr_q),
      .ptr_q    (ptr_q),
      .phase_q  (phase_q),
      .col_done (col_done)
   );

   // ---------------- palette write path ----------------
   logic [NARROW_W-1:0] hold_q;
   logic [COL_W-1:0]    col_wval;
   logic [NCOL-1:0]     we_lane;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (wr_en && sel_t == SEL_PAL && two_step && !phase_q)
         hold_q <= wdata[NARROW_W-1:0];
   end

   always_comb begin
      if (two_step)    col_wval = {hold_q, wdata[LSB_W-1:0]};
      else if (res10)  col_wval = wdata;
      else             col_wval = {wdata[NARROW_W-1:0], {LSB_W{1'b0}}};
   end

   always_comb begin
      for (int i = 0; i < NCOL; i++)
         we_lane[i] = wr_en && col_done && (ptr_q == PTR_W'(i));
   end

   logic [PIX_W-1:0] pal_a, pal_b;

   clut_palette_ram #(.ADDR_W(ADDR_W), .COL_W(COL_W), .NCOL(NCOL)) u_ram (
      .clk     (clk),
      .we_lane (we_lane),
      .waddr   (addr_q),
      .wval    (col_wval),
      .raddr_a (addr_q),
      .rval_a  (pal_a),
      .raddr_b (lk_idx),
      .rval_b  (pal_b)
   );

   // ---------------- control registers ----------------
   logic [CTRL_W-1:0] ctrl_rval;

   clut_ctrl_regs #(
      .NREG(NCTRL), .CTRL_W(CTRL_W), .IDX_W(CIDX_W), .RST_VALS(CTRL_RST)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && sel_t == SEL_CTRL),
      .idx   (addr_q[CIDX_W-1:0]),
      .wval  (wdata[CTRL_W-1:0]),
      .rval  (ctrl_rval)
   );

   // ---------------- host read path ----------------
   logic [COL_W-1:0] cur_col;
   logic [BUS_W-1:0] pal_rval, rd_val;

   always_comb begin
      cur_col = '0;
      for (int i = 0; i < NCOL; i++)
         if (ptr_q == PTR_W'(i)) cur_col = pal_a[(NCOL-1-i)*COL_W +: COL_W];
   end

   always_comb begin
      if (two_step)
         pal_rval = phase_q ? BUS_W'(cur_col[LSB_W-1:0])
                            : BUS_W'(cur_col[COL_W-1:LSB_W]);
      else if (res10)
         pal_rval = cur_col;
      else
         pal_rval = BUS_W'(cur_col[COL_W-1:LSB_W]);
   end

   always_comb begin
      unique case (sel_t)
         SEL_ADDR: rd_val = BUS_W'(addr_q);
         SEL_PAL:  rd_val = pal_rval;
         SEL_MODE: rd_val = BUS_W'(mode_q);
         default:  rd_val = BUS_W'(ctrl_rval);
      endcase
      if (!bus10) rd_val[BUS_W-1:NARROW_W] = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   // ---------------- pixel-side lookup ----------------
   logic [PIX_W-1:0] lk_mask;

   for (genvar g = 0; g < NCOL; g++) begin : g_mask
      assign lk_mask[g*COL_W +: COL_W] = {{NARROW_W{1'b1}}, {LSB_W{res10}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lk_rgb <= '0;
      else        lk_rgb <= pal_b & lk_mask;
   end
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk #(
   parameter int ADDR_W = 8,
   parameter int COL_W  = 10,
   parameter int NCOL   = 3,
   parameter int LSB_W  = 2,
   localparam int PTR_W = (NCOL > 1) ? $clog2(NCOL) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cs,
   input logic                  rd,
   input logic                  wr,
   input logic [1:0]            sel,
   input logic [COL_W-1:0]      rdata,
   input logic [NCOL*COL_W-1:0] lk_rgb,
   input logic [ADDR_W-1:0]     addr,
   input logic [PTR_W-1:0]      ptr,
   input logic                  phase,
   input logic                  col_done,
   input logic                  res10,
   input logic                  bus10
);
   logic [NCOL*COL_W-1:0] low_bits;
   for (genvar g = 0; g < NCOL; g++) begin : g_low
      assign low_bits[g*COL_W +: COL_W] = {{(COL_W-LSB_W){1'b0}}, {LSB_W{1'b1}}};
   end

   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr < PTR_W'(NCOL)); // R4

   AST_INC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (col_done && ptr == PTR_W'(NCOL-1)) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R4

   AST_ADDR_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && sel == 2'd0) |=> (ptr == '0 && !phase)); // R7

   AST_MODE_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && !wr && sel == 2'd2) |=> rdata[COL_W-1:COL_W-LSB_W] == '0); // R3

   AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && !wr && !bus10) |=> rdata[COL_W-1:COL_W-LSB_W] == '0); // R9

   AST_LOW_PREC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !res10 |=> (lk_rgb & low_bits) == '0); // R8
endmodule

bind clut_host_port clut_host_port_chk #(
   .ADDR_W(ADDR_W), .COL_W(COL_W), .NCOL(NCOL), .LSB_W(LSB_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs),
   .rd       (rd),
   .wr       (wr),
   .sel      (sel),
   .rdata    (rdata),
   .lk_rgb   (lk_rgb),
   .addr     (addr_q),
   .ptr      (ptr_q),
   .phase    (phase_q),
   .col_done (col_done),
   .res10    (res10),
   .bus10    (bus10)
);

// File: tb/clut_host_port_test.sv
module clut_host_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [1:0]  sel = 2'd0;
   logic [9:0]  wdata = '0;
   logic [9:0]  rdata;
   logic        op_normal;
   logic [7:0]  lk_idx = '0;
   logic [29:0] lk_rgb;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clut_host_port uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .sel(sel),
      .wdata(wdata), .rdata(rdata), .op_normal(op_normal),
      .lk_idx(lk_idx), .lk_rgb(lk_rgb)
   );

   localparam logic [1:0] S_ADDR = 2'd0, S_PAL = 2'd1, S_MODE = 2'd2, S_CTRL = 2'd3;

   task automatic check(input string req, input logic [29:0] got, input logic [29:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] s, input logic [9:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] s, output logic [9:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; sel = s;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
      d = rdata;
   endtask

   task automatic look(input logic [7:0] idx, output logic [29:0] v);
      @(negedge clk);
      lk_idx = idx;
      @(negedge clk);
      v = lk_rgb;
   endtask

   task automatic t_reset;
      logic [9:0] v;
      bus_rd(S_ADDR, v); check("R1 addr", 30'(v), 30'h000);
      bus_rd(S_MODE, v); check("R1 mode", 30'(v), 30'h0FF);
      check("R1 op_normal", 30'(op_normal), 30'h0);
      bus_rd(S_CTRL, v); check("R1 ctrl0", 30'(v), 30'h000);
      bus_wr(S_ADDR, 10'h001);
      bus_rd(S_CTRL, v); check("R1 ctrl1", 30'(v), 30'h0FF);
      bus_wr(S_ADDR, 10'h002);
      bus_rd(S_CTRL, v); check("R1 ctrl2", 30'(v), 30'h0FF);
   endtask

   task automatic t_regs;
      logic [9:0] v;
      bus_wr(S_ADDR, 10'h3FF);
      bus_rd(S_ADDR, v); check("R2 addr FF", 30'(v), 30'h0FF);
      bus_wr(S_ADDR, 10'h2A5);
      bus_rd(S_ADDR, v); check("R2 addr A5", 30'(v), 30'h0A5);
      bus_wr(S_ADDR, 10'h001);
      bus_wr(S_CTRL, 10'h35A);
      bus_rd(S_CTRL, v); check("R13 ctrl1 write", 30'(v), 30'h05A);
      bus_wr(S_ADDR, 10'h000);
      bus_rd(S_CTRL, v); check("R13 ctrl0 untouched", 30'(v), 30'h000);
      bus_wr(S_MODE, 10'h3FE);
      bus_rd(S_MODE, v); check("R3 mode reserved", 30'(v), 30'h0FE);
   endtask

   task automatic t_opmode;
      bus_wr(S_MODE, 10'h006); check("R11 op 00", 30'(op_normal), 30'h0);
      bus_wr(S_MODE, 10'h016); check("R11 op 10", 30'(op_normal), 30'h0);
      bus_wr(S_MODE, 10'h01E); check("R11 op 11", 30'(op_normal), 30'h0);
      bus_wr(S_MODE, 10'h00E); check("R11 op 01", 30'(op_normal), 30'h1);
   endtask

   task automatic t_wide;
      logic [9:0]  v;
      logic [29:0] p;
      bus_wr(S_ADDR, 10'h010);
      bus_wr(S_PAL, 10'h3A1); bus_wr(S_PAL, 10'h155); bus_wr(S_PAL, 10'h2CC);
      bus_wr(S_PAL, 10'h001); bus_wr(S_PAL, 10'h3FF); bus_wr(S_PAL, 10'h200);
      bus_rd(S_ADDR, v); check("R4 addr after two triples", 30'(v), 30'h012);
      look(8'h10, p); check("R10 R12 lookup 10", p, {10'h3A1, 10'h155, 10'h2CC});
      look(8'h11, p); check("R12 lookup 11", p, {10'h001, 10'h3FF, 10'h200});
      bus_wr(S_ADDR, 10'h030);
      bus_wr(S_PAL, 10'h011); bus_wr(S_PAL, 10'h022);
      bus_rd(S_ADDR, v); check("R4 no inc mid triple", 30'(v), 30'h030);
      bus_wr(S_PAL, 10'h033);
      bus_rd(S_ADDR, v); check("R4 inc after blue", 30'(v), 30'h031);
   endtask

   task automatic t_read_seq;
      logic [9:0] v;
      bus_wr(S_ADDR, 10'h010);
      bus_rd(S_PAL, v); check("R5 red 10", 30'(v), 30'h3A1);
      bus_rd(S_PAL, v); check("R5 green 10", 30'(v), 30'h155);
      bus_rd(S_PAL, v); check("R5 blue 10", 30'(v), 30'h2CC);
      bus_rd(S_PAL, v); check("R5 red 11", 30'(v), 30'h001);
      bus_rd(S_PAL, v); check("R5 green 11", 30'(v), 30'h3FF);
      bus_rd(S_PAL, v); check("R5 blue 11", 30'(v), 30'h200);
      bus_rd(S_ADDR, v); check("R5 addr after reads", 30'(v), 30'h012);
   endtask

   task automatic t_restart_wrap;
      logic [9:0]  v;
      logic [29:0] p;
      bus_wr(S_ADDR, 10'h040);
      bus_wr(S_PAL, 10'h111);
      bus_wr(S_ADDR, 10'h040);
      bus_wr(S_PAL, 10'h0AA); bus_wr(S_PAL, 10'h0BB); bus_wr(S_PAL, 10'h0CC);
      look(8'h40, p); check("R7 restart at red", p, {10'h0AA, 10'h0BB, 10'h0CC});
      bus_wr(S_ADDR, 10'h0FF);
      bus_wr(S_PAL, 10'h101); bus_wr(S_PAL, 10'h202); bus_wr(S_PAL, 10'h303);
      bus_rd(S_ADDR, v); check("R6 wrap to 0", 30'(v), 30'h000);
      look(8'hFF, p); check("R6 entry 255", p, {10'h101, 10'h202, 10'h303});
   endtask

   task automatic t_low_prec;
      logic [9:0]  v;
      logic [29:0] p;
      bus_wr(S_MODE, 10'h00C);
      look(8'h10, p); check("R8 lookup mask", p, {10'h3A0, 10'h154, 10'h2CC});
      bus_wr(S_ADDR, 10'h050);
      bus_wr(S_PAL, 10'h3AB); bus_wr(S_PAL, 10'h0CD); bus_wr(S_PAL, 10'h012);
      bus_rd(S_ADDR, v); check("R8 one transfer per colour", 30'(v), 30'h051);
      bus_wr(S_ADDR, 10'h050);
      bus_rd(S_PAL, v); check("R8 read red", 30'(v), 30'h0AB);
      bus_wr(S_MODE, 10'h00E);
      look(8'h50, p); check("R8 stored shifted", p, {10'h2AC, 10'h334, 10'h048});
   endtask

   task automatic t_narrow;
      logic [9:0]  v;
      logic [29:0] p;
      bus_wr(S_ADDR, 10'h060);
      bus_wr(S_PAL, 10'h000); bus_wr(S_PAL, 10'h000); bus_wr(S_PAL, 10'h000);
      bus_wr(S_MODE, 10'h00A);
      bus_wr(S_ADDR, 10'h060);
      bus_wr(S_PAL, 10'h3E7);
      look(8'h60, p); check("R9 no commit after MSB step", p, 30'h0);
      bus_wr(S_PAL, 10'h002);
      bus_wr(S_PAL, 10'h012); bus_wr(S_PAL, 10'h001);
      bus_wr(S_PAL, 10'h0FF);
      bus_rd(S_ADDR, v); check("R9 no inc before last LSB step", 30'(v), 30'h060);
      bus_wr(S_PAL, 10'h003);
      bus_rd(S_ADDR, v); check("R9 inc after last LSB step", 30'(v), 30'h061);
      look(8'h60, p); check("R9 assembled entry", p, {10'h39E, 10'h049, 10'h3FF});
      bus_wr(S_ADDR, 10'h010);
      bus_rd(S_PAL, v); check("R9 read red MSB", 30'(v), 30'h0E8);
      bus_rd(S_PAL, v); check("R9 read red LSB", 30'(v), 30'h001);
      bus_wr(S_MODE, 10'h3CA);
      bus_rd(S_MODE, v); check("R9 narrow top zero", 30'(v), 30'h0CA);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_opmode();
      t_wide();
      t_read_seq();
      t_restart_wrap();
      t_low_prec();
      t_narrow();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule